// File: doc/BRIEF.md
# Serial Audio Reformatter for Non-Oversampling Multibit DACs

This block accepts a two-channel I2S stream of 16-bit samples carried in 32-bit slots (a bit clock at 64 times the sample rate). It sends the samples on to a multibit DAC as a new serial stream with its own bit clock, word select and data. By default the outgoing bit clock runs at half the incoming rate, so each data bit lasts two incoming bit periods. The outgoing stream carries exactly 16 bits per word with no padding.

Pins choose how the two channels are routed. Stereo passes left and right straight through. Duplicate puts one chosen channel on both outputs. Differential puts one chosen channel on the left output and its saturated negation on the right. A separate repeat pin sends every sample pair twice per input frame, which doubles the word rate and keeps the bit clock at the incoming rate. The block runs on one fast system clock and samples the incoming serial lines through synchronisers. It follows both edges of the incoming bit clock.

Top module: `dacfmt_top`

## Requirements
- R1: After reset, dac_bclk, dac_ws and dac_sd are all low. They stay low until the first left-channel start (a falling edge of i2s_ws) is seen.
- R2: Input bits are sampled on rising edges of i2s_bclk. A word starts on the second rising edge after i2s_ws changes and is taken MSB first for 16 bits. Slot bits after the 16th, and the bit at the word-select change, are ignored.
- R3: The left and right samples received in one input frame are emitted during the next input frame, left word first. dac_ws is 0 while a left word is sent and 1 while a right word is sent, and it changes only when dac_bclk falls.
- R4: With repeat off, every output bit is held for two input bit periods, so dac_bclk has twice the input bit-clock period and there are 32 dac_bclk cycles per frame. dac_sd changes only when dac_bclk falls, and the DAC samples it on the rising edge.
- R5: With repeat on (rpt_en=1), dac_bclk has the input bit-clock period, and the pair of one frame is sent twice in the order left, right, left, right.
- R6: mode_sel=0 (stereo) and mode_sel=3 (treated as stereo) send the left sample as the left word and the right sample as the right word.
- R7: mode_sel=1 (duplicate) sends the source sample as both words. src_right=0 picks the left input channel and src_right=1 picks the right one.
- R8: mode_sel=2 (differential) sends the source sample (chosen by src_right as in R7) as the left word and its two's-complement negation as the right word.
- R9: In differential mode a source of 0x8000 gives a right word of 0x7FFF instead of wrapping.
- R10: mode_sel, src_right and rpt_en are read only at the left-channel start of each frame. A change during a frame has no effect on the output already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the input bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| i2s_bclk | input | 1 | Incoming bit clock, 64 per frame |
| i2s_ws | input | 1 | Incoming word select, 0 = left |
| i2s_sd | input | 1 | Incoming serial data |
| mode_sel | input | 2 | Routing: 0 stereo, 1 duplicate, 2 differential, 3 stereo |
| src_right | input | 1 | Source channel for duplicate and differential modes |
| rpt_en | input | 1 | Send every sample pair twice at the doubled word rate |
| dac_bclk | output | 1 | Outgoing bit clock |
| dac_ws | output | 1 | Outgoing word select, 0 = left word |
| dac_sd | output | 1 | Outgoing serial data, MSB first |

## Verification
The hardest case to reach from the ports is a configuration change that lands while a frame is already being sent. The outgoing word must then follow the settings latched one frame earlier, and a change of the repeat pin also changes the bit rate between two frames. The stimulus moves the pins in the middle of every frame and steps through all sixteen combinations of routing, source and repeat. Every frame carries 0x8000, 0x7FFF, all-ones, a walking bit or a pseudo-random pattern, with ones in the unused slot bits, so the saturation case and the padding case both come up under every mode.

// File: rtl/dacfmt_pkg.sv
// Shared types for the DAC stream reformatter.
// Assumes: nothing beyond a two-bit routing selector.
package dacfmt_pkg;

    // Channel routing applied to each sample pair.
    typedef enum logic [1:0] {
        MIX_STEREO   = 2'd0,
        MIX_DUP      = 2'd1,
        MIX_DIFF     = 2'd2,
        MIX_STEREO_B = 2'd3
    } mix_mode_t;

    // Configuration latched once per frame.
    typedef struct packed {
        mix_mode_t mode;
        logic      src_right;
        logic      rpt;
    } fmt_cfg_t;

endpackage

// File: rtl/i2s_rx.sv
// I2S receiver running on the system clock.
// Synchronises the serial lines, finds both bit-clock edges and captures
// WORD_W bits MSB first, starting one bit after each word-select change.
// Assumes: the system clock is at least four times faster than the bit clock.
module i2s_rx #(
    parameter int WORD_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_in,
    input  logic              ws_in,
    input  logic              sd_in,
    output logic              frame_start,
    output logic              bit_edge,
    output logic [WORD_W-1:0] left_word,
    output logic [WORD_W-1:0] right_word
);
    localparam int POS_W = $clog2(WORD_W + 1);

    logic [SYNC_STAGES-1:0] bclk_sy, ws_sy, sd_sy;
    logic                   bclk_d, ws_last;
    logic [POS_W-1:0]       pos;
    logic [WORD_W-1:0]      sh_l, sh_r;
    logic                   b_now, w_now, d_now;
    logic                   rise, fall, ws_chg, take;

    assign b_now  = bclk_sy[SYNC_STAGES-1];
    assign w_now  = ws_sy[SYNC_STAGES-1];
    assign d_now  = sd_sy[SYNC_STAGES-1];
    assign rise   = b_now & ~bclk_d;
    assign fall   = ~b_now & bclk_d;
    assign ws_chg = rise && (w_now != ws_last);
    assign take   = rise && !ws_chg && (pos < POS_W'(WORD_W));

    assign frame_start = ws_chg && !w_now;
    assign bit_edge    = rise | fall;
    assign left_word   = sh_l;
    assign right_word  = sh_r;

    // Bring the asynchronous serial lines into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_sy <= '0;
            ws_sy   <= '0;
            sd_sy   <= '0;
            bclk_d  <= 1'b0;
        end else begin
            bclk_sy <= (bclk_sy << 1) | SYNC_STAGES'(bclk_in);
            ws_sy   <= (ws_sy << 1) | SYNC_STAGES'(ws_in);
            sd_sy   <= (sd_sy << 1) | SYNC_STAGES'(sd_in);
            bclk_d  <= b_now;
        end
    end

    // Track the bit position inside the current word slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_last <= 1'b0;
            pos     <= '0;
        end else if (rise) begin
            ws_last <= w_now;
            if (ws_chg)
                pos <= '0;
            else if (take)
                pos <= pos + 1'b1;
        end
    end

    // Shift captured bits into the register of the active channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_l <= '0;
            sh_r <= '0;
        end else if (take) begin
            if (w_now)
                sh_r <= {sh_r[WORD_W-2:0], d_now};
            else
                sh_l <= {sh_l[WORD_W-2:0], d_now};
        end
    end

endmodule

// File: rtl/fmt_mix.sv
// Channel router: picks the stereo, duplicate or differential word pair.
// The negation saturates the most negative code to the most positive one.
// Assumes: purely combinational; the caller registers the result.
module fmt_mix
    import dacfmt_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  fmt_cfg_t          cfg,
    input  logic [WORD_W-1:0] in_l,
    input  logic [WORD_W-1:0] in_r,
    output logic [WORD_W-1:0] out_l,
    output logic [WORD_W-1:0] out_r
);
    localparam logic [WORD_W-1:0] MOST_NEG = {1'b1, {(WORD_W-1){1'b0}}};
    localparam logic [WORD_W-1:0] MOST_POS = {1'b0, {(WORD_W-1){1'b1}}};

    logic [WORD_W-1:0] src, neg;

    // Pick the source channel and form its saturated negation.
    always_comb begin
        src = cfg.src_right ? in_r : in_l;
        neg = (src == MOST_NEG) ? MOST_POS : (~src + 1'b1);
    end

    // Route the words according to the selected mode.
    always_comb begin
        unique case (cfg.mode)
            MIX_DUP: begin
                out_l = src;
                out_r = src;
            end
            MIX_DIFF: begin
                out_l = src;
                out_r = neg;
            end
            default: begin
                out_l = in_l;
                out_r = in_r;
            end
        endcase
    end

endmodule

// File: rtl/dac_ser.sv
// Output serialiser. A half-tick counter follows every input bit-clock edge
// and restarts at each frame start. Without repeat a bit spans four
// half-ticks; with repeat it spans two, and the frame is sent twice.
// Assumes: WORD_W is a power of two and a frame holds 8*WORD_W edges.
module dac_ser #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              bit_edge,
    input  logic              rpt,
    input  logic [WORD_W-1:0] word_l,
    input  logic [WORD_W-1:0] word_r,
    output logic              dac_bclk,
    output logic              dac_ws,
    output logic              dac_sd
);
    localparam int CNT_W = $clog2(8 * WORD_W);
    localparam int BIT_W = CNT_W - 2;
    localparam int IDX_W = BIT_W - 1;

    logic [CNT_W-1:0] ht;
    logic             active;
    logic [BIT_W-1:0] bnum;
    logic [IDX_W-1:0] bpos;
    logic             clk_bit, ch, dbit;

    // Count half-ticks of the input bit clock inside a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ht     <= '0;
            active <= 1'b0;
        end else if (load) begin
            ht     <= '0;
            active <= 1'b1;
        end else if (bit_edge && active) begin
            ht <= ht + 1'b1;
        end
    end

    // Decode bit number, channel and clock phase from the counter.
    always_comb begin
        bnum    = rpt ? ht[CNT_W-2:1] : ht[CNT_W-1:2];
        clk_bit = rpt ? ht[0] : ht[1];
        ch      = bnum[BIT_W-1];
        bpos    = ~bnum[IDX_W-1:0];
        dbit    = ch ? word_r[bpos] : word_l[bpos];
    end

    // Register the serial outputs, held low until the first frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_bclk <= 1'b0;
            dac_ws   <= 1'b0;
            dac_sd   <= 1'b0;
        end else begin
            dac_bclk <= active & clk_bit;
            dac_ws   <= active & ch;
            dac_sd   <= active & dbit;
        end
    end

endmodule

// File: rtl/dacfmt_top.sv
// Top of the DAC stream reformatter: receiver, router, frame holding
// registers and output serialiser. Configuration and words are latched
// together at each left-channel start, which gives one frame of latency.
// Assumes: synchronous active-low reset; serial inputs are asynchronous.
module dacfmt_top
    import dacfmt_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       i2s_bclk,
    input  logic       i2s_ws,
    input  logic       i2s_sd,
    input  logic [1:0] mode_sel,
    input  logic       src_right,
    input  logic       rpt_en,
    output logic       dac_bclk,
    output logic       dac_ws,
    output logic       dac_sd
);
    logic              frame_start, bit_edge;
    logic [WORD_W-1:0] rx_l, rx_r, mix_l, mix_r;
    logic [WORD_W-1:0] hold_l, hold_r;
    fmt_cfg_t          cfg_live, cfg_q;

    assign cfg_live = '{mode: mix_mode_t'(mode_sel), src_right: src_right, rpt: rpt_en};

    i2s_rx #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) rx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk_in    (i2s_bclk),
        .ws_in      (i2s_ws),
        .sd_in      (i2s_sd),
        .frame_start(frame_start),
        .bit_edge   (bit_edge),
        .left_word  (rx_l),
        .right_word (rx_r)
    );

    fmt_mix #(.WORD_W(WORD_W)) mix_i (
        .cfg  (cfg_live),
        .in_l (rx_l),
        .in_r (rx_r),
        .out_l(mix_l),
        .out_r(mix_r)
    );

    // Latch the routed pair and the configuration at each frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_l <= '0;
            hold_r <= '0;
            cfg_q  <= '{mode: MIX_STEREO, src_right: 1'b0, rpt: 1'b0};
        end else if (frame_start) begin
            hold_l <= mix_l;
            hold_r <= mix_r;
            cfg_q  <= cfg_live;
        end
    end

    dac_ser #(.WORD_W(WORD_W)) ser_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (frame_start),
        .bit_edge(bit_edge),
        .rpt     (cfg_q.rpt),
        .word_l  (hold_l),
        .word_r  (hold_r),
        .dac_bclk(dac_bclk),
        .dac_ws  (dac_ws),
        .dac_sd  (dac_sd)
    );

endmodule

// File: rtl/dacfmt_chk.sv
// Property checker for the reformatter, attached to the top by bind.
// Assumes: sees the top's ports plus its latched frame state.
module dacfmt_chk
    import dacfmt_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dac_bclk,
    input logic              dac_ws,
    input logic              dac_sd,
    input logic              frame_start,
    input fmt_cfg_t          cfg_q,
    input logic [WORD_W-1:0] hold_l,
    input logic [WORD_W-1:0] hold_r
);
    localparam logic [WORD_W-1:0] MOST_NEG = {1'b1, {(WORD_W-1){1'b0}}};

    logic seen_frame;

    // Remember whether any frame start has happened since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seen_frame <= 1'b0;
        else if (frame_start)
            seen_frame <= 1'b1;
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_frame |-> (!dac_bclk && !dac_ws && !dac_sd));

    // R4
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_bclk |-> ($stable(dac_sd) && $stable(dac_ws)));

    // R3
    ws_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_ws) |-> $fell(dac_bclk));

    // R10
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_q) |-> $past(frame_start));

    // R7
    dup_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.mode == MIX_DUP) |-> (hold_l == hold_r));

    // R9
    diff_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.mode == MIX_DIFF) |-> (hold_r != MOST_NEG));

endmodule

bind dacfmt_top dacfmt_chk #(.WORD_W(WORD_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .dac_bclk   (dac_bclk),
    .dac_ws     (dac_ws),
    .dac_sd     (dac_sd),
    .frame_start(frame_start),
    .cfg_q      (cfg_q),
    .hold_l     (hold_l),
    .hold_r     (hold_r)
);

// File: tb/dacfmt_top_tb_top.sv
// Self-checking bench: sweeps every routing/source/repeat combination with
// corner and pseudo-random samples, and rebuilds the words at dac_bclk rises.
module dacfmt_top_tb_top;
    localparam int HALF = 2;  // system clocks per half input bit period

    logic       clk = 1'b0;
    logic       rst_n;
    logic       i2s_bclk, i2s_ws, i2s_sd;
    logic [1:0] mode_sel;
    logic       src_right, rpt_en;
    logic       dac_bclk, dac_ws, dac_sd;

    int nchk = 0;
    int nbad = 0;
    bit done = 0;

    logic [15:0] exp_w[$];
    string       exp_t[$];
    int          exp_p[$];

    always #5 clk = ~clk;

    dacfmt_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .i2s_bclk(i2s_bclk), .i2s_ws(i2s_ws), .i2s_sd(i2s_sd),
        .mode_sel(mode_sel), .src_right(src_right), .rpt_en(rpt_en),
        .dac_bclk(dac_bclk), .dac_ws(dac_ws), .dac_sd(dac_sd)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] sat_neg(input logic [15:0] v);
        int n;
        n = -int'($signed(v));
        if (n > 32767) n = 32767;
        return n[15:0];
    endfunction

    // Push the expected output words for one frame of input.
    task automatic push_frame(input logic [15:0] l, input logic [15:0] r,
                              input logic [1:0] m, input logic s, input logic rp,
                              input bit changed);
        logic [15:0] ol, or_, src;
        string tg;
        src = s ? r : l;
        case (m)
            2'd1: begin ol = src; or_ = src; tg = "R7"; end
            2'd2: begin
                ol = src; or_ = sat_neg(src);
                tg = (src == 16'h8000) ? "R8/R9" : "R8";
            end
            default: begin ol = l; or_ = r; tg = "R6"; end
        endcase
        tg = {"R2/R3/", tg, rp ? "/R5" : "", changed ? "/R10" : ""};
        for (int k = 0; k < (rp ? 2 : 1); k++) begin
            exp_w.push_back(ol);  exp_t.push_back(tg); exp_p.push_back(rp ? 4*HALF/2 : 4*HALF);
            exp_w.push_back(or_); exp_t.push_back(tg); exp_p.push_back(rp ? 4*HALF/2 : 4*HALF);
        end
    endtask

    task automatic send_period(input logic ws, input logic sd);
        i2s_bclk = 1'b0; i2s_ws = ws; i2s_sd = sd;
        repeat (HALF) @(negedge clk);
        i2s_bclk = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    // Send one frame; new pins are applied in the middle of the frame.
    task automatic send_frame(input logic [15:0] l, input logic [15:0] r,
                              input logic [1:0] m, input logic s, input logic rp);
        for (int p = 0; p < 64; p++) begin
            int sl;
            logic [15:0] w;
            logic d;
            sl = p % 32;
            w  = (p < 32) ? l : r;
            d  = (sl >= 1 && sl <= 16) ? w[16-sl] : 1'b1;
            if (p == 32) begin
                mode_sel = m; src_right = s; rpt_en = rp;
            end
            send_period(p >= 32, d);
        end
    endtask

    // Monitor: rebuild words from dac_bclk rises and compare them.
    logic        prev_b = 1'b0;
    int          bitn = 0, cyc = 0, last_rise = 0, wc = 0, bad_sp = 0, sp_seen = 0;
    logic [15:0] acc;
    logic        ws_first;
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            prev_b = 1'b0; bitn = 0;
        end else begin
            if (dac_bclk && !prev_b) begin
                if (bitn == 0) begin
                    ws_first = dac_ws; bad_sp = 0; sp_seen = 0;
                end else if (exp_p.size() > 0 && (cyc - last_rise) != exp_p[0]) begin
                    bad_sp = 1; sp_seen = cyc - last_rise;
                end
                acc = {acc[14:0], dac_sd};
                last_rise = cyc;
                bitn++;
                if (bitn == 16) begin
                    bitn = 0;
                    if (exp_w.size() == 0) begin
                        check(0, "R3", "unexpected word", int'(acc), 0);
                    end else begin
                        logic [15:0] ew; string et; int ep;
                        ew = exp_w.pop_front(); et = exp_t.pop_front(); ep = exp_p.pop_front();
                        check(acc == ew, et, "word", int'(acc), int'(ew));
                        check(ws_first == wc[0], "R3", "word select", int'(ws_first), wc % 2);
                        check(!bad_sp, (ep == 4*HALF) ? "R4" : "R5", "bit period",
                              sp_seen, ep);
                    end
                    wc++;
                end
            end
            prev_b = dac_bclk;
        end
    end

    initial begin
        logic [15:0] lfsr;
        logic [3:0]  prev_cfg;
        rst_n = 1'b0; i2s_bclk = 1'b0; i2s_ws = 1'b1; i2s_sd = 1'b0;
        mode_sel = 2'd0; src_right = 1'b0; rpt_en = 1'b0;
        repeat (5) @(negedge clk);
        check(!dac_bclk && !dac_ws && !dac_sd, "R1", "outputs in reset",
              {dac_bclk, dac_ws, dac_sd}, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 40; i++) send_period(1'b1, 1'b0);
        check(!dac_bclk && !dac_ws && !dac_sd, "R1", "outputs before first frame",
              {dac_bclk, dac_ws, dac_sd}, 0);
        push_frame(16'h0, 16'h0, 2'd0, 1'b0, 1'b0, 1'b0);
        lfsr = 16'hACE1;
        prev_cfg = 4'd0;
        for (int c = 0; c < 16; c++) begin
            logic [3:0] cf;
            cf = 4'(c);
            for (int f = 0; f < 6; f++) begin
                logic [15:0] l, r;
                case (f)
                    0: begin l = 16'h8000; r = 16'h7FFF; end
                    1: begin l = 16'h7FFF; r = 16'h8000; end
                    2: begin l = 16'h0000; r = 16'hFFFF; end
                    3: begin l = 16'h1 << c; r = ~(16'h1 << c); end
                    default: begin
                        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                        l = lfsr;
                        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                        r = lfsr;
                    end
                endcase
                push_frame(l, r, cf[1:0], cf[2], cf[3], (f == 0) && (cf != prev_cfg));
                send_frame(l, r, cf[1:0], cf[2], cf[3]);
            end
            prev_cfg = cf;
        end
        // Flush frame: its own data is never sent, it only drains the last one.
        send_frame(16'h0, 16'h0, 2'd0, 1'b0, 1'b0);
        i2s_bclk = 1'b0;
        repeat (600) @(negedge clk);
        check(exp_w.size() == 0, "R3", "words left unsent", exp_w.size(), 0);
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++; nbad++;
            $display("FAIL R3 watchdog expired actual=%0h expected=%0h", 1, 0);
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

endmodule